// File: doc/BRIEF.md
# Serial ADC Conversion Read-Out Controller

This block sits on the host side of a three-wire link to an external 10-bit successive-approximation converter. A one-cycle start request in idle pulls chip select low with the serial clock held low, which makes the converter sample its input and convert. The controller then watches the returned data line for its low-to-high end-of-conversion edge. When that edge arrives it runs a serial clock derived from the system clock and samples the data line on each rising edge. At the end of the frame it raises chip select and hands back the 10-bit code with a one-cycle done pulse.

Two read lengths are offered, chosen per conversion. The short read stops after 11 clocks: one framing bit and ten result bits. The byte read issues 16 clocks so that a byte-oriented host sees two whole bytes, and the controller throws away everything beyond the result bits. If no end-of-conversion edge is seen within a bounded wait, the conversion is abandoned. Chip select is raised, the done pulse carries a timeout flag, and a longer recovery gap is enforced before the next start.

Chip select is always kept high for a minimum time between frames. After reset, and after a wake notice (the converter has just left shutdown), the controller refuses conversions for a configurable settling interval. All delays are parameters counted in system-clock cycles.

Top module: `adc_rd_ctrl`

## Requirements
- R1: From reset release, busy_o is high and cs_n_o stays high for at least PWRUP_CYC cycles; start_i is ignored during that interval. During reset cs_n_o=1, sclk_o=0, done_o=0 and busy_o=1.
- R2: A start_i pulse while idle lowers cs_n_o on the next clock edge, and sclk_o stays low until end of conversion has been detected.
- R3: End of conversion is a 0-to-1 change on sdat_i while cs_n_o is low, after a two-flop synchronizer. The first sclk_o rise follows exactly DIV_HALF+3 cycles after the data line goes high.
- R4: sclk_o is low whenever cs_n_o is high. Each high phase of sclk_o lasts exactly DIV_HALF cycles, and each low phase between two rises does too.
- R5: With byte_mode_i=0 at start, exactly 11 rising edges are issued. The first sampled bit is the framing 1 and is dropped; result_o holds samples 2 to 11, the first of them landing in bit 9.
- R6: With byte_mode_i=1 at start, exactly 16 rising edges are issued and result_o holds samples 2 to 11. The two sub-bits and the padding in samples 12 to 16 do not affect result_o.
- R7: cs_n_o rises only after the last falling edge of sclk_o, with sclk_o low for at least DIV_HALF cycles. done_o is a one-cycle pulse in the same cycle as that rise, with result_o and timeout_o valid.
- R8: After a completed frame, busy_o falls exactly CSHI_CYC+1 cycles after cs_n_o rises. cs_n_o is never low again until it has been high for more than CSHI_CYC cycles.
- R9: If no end of conversion is detected, cs_n_o rises exactly CONV_TMO+1 cycles after it fell, with no sclk_o pulse. done_o pulses with timeout_o=1 and result_o=0. timeout_o is cleared by the next start.
- R10: After a timeout, busy_o falls exactly ABORT_CYC+1 cycles after cs_n_o rises.
- R11: A wake_i pulse while idle and not starting holds busy_o high for WAKE_CYC+1 cycles and starts no frame.
- R12: start_i while busy_o is high starts no additional frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion (taken only while idle) |
| byte_mode_i | input | 1 | Read length for this conversion: 0 = 11 clocks, 1 = 16 clocks |
| wake_i | input | 1 | Converter has just left shutdown; apply the wake hold-off |
| busy_o | output | 1 | High whenever the controller is not idle |
| done_o | output | 1 | One-cycle pulse when a conversion ends |
| result_o | output | 10 | Converted code, valid with done_o |
| timeout_o | output | 1 | End of conversion was never seen for the last conversion |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idle low |
| sdat_i | input | 1 | Serial data from the converter |

## Verification
The assertions assume that sdat_i changes only during a conversion or within one cycle after a falling edge of sclk_o. They also assume that DIV_HALF is at least 4, which leaves the synchronizer time to settle before each sampling edge, and that PWRUP_CYC exceeds CSHI_CYC. The converter model in the bench meets these assumptions. It drives the line high while chip select is high, low during conversion and high at end of conversion. It shifts one bit on the clock edge that follows each serial-clock fall, and the bench runs with a divider of 5. Conversion lengths are chosen well inside the timeout, or made endless to force the abort path.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  localparam int RES_W     = 10;
  localparam int SHORT_LEN = 11;
  localparam int BYTE_LEN  = 16;
  localparam int CAP_W     = BYTE_LEN;
  localparam int BCNT_W    = $clog2(BYTE_LEN + 1);

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_IDLE,
    ST_CONV,
    ST_SHIFT,
    ST_TAIL
  } rd_state_e;

  function automatic int max_of(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // number of rising edges issued for one read
  function automatic logic [BCNT_W-1:0] frame_len(logic byte_mode);
    return byte_mode ? BCNT_W'(BYTE_LEN) : BCNT_W'(SHORT_LEN);
  endfunction

  // samples enter at bit 0; the oldest (framing) sample sits highest
  function automatic logic [RES_W-1:0] extract_result(logic [CAP_W-1:0] cap,
                                                      logic byte_mode);
    return byte_mode ? cap[CAP_W-2 -: RES_W] : cap[RES_W-1:0];
  endfunction

endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int PH_W = $clog2(DIV_HALF + 1);

  logic [PH_W-1:0] ph_q;
  logic            lvl_q;
  logic            ph_end;

  assign ph_end = run_i && (ph_q == PH_W'(DIV_HALF - 1));
  assign rise_o = ph_end && !lvl_q;
  assign fall_o = ph_end && lvl_q;
  assign sclk_o = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      lvl_q <= 1'b0;
    end else if (!run_i) begin
      ph_q  <= '0;
      lvl_q <= 1'b0;
    end else if (ph_end) begin
      ph_q  <= '0;
      lvl_q <= !lvl_q;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  // R4: stopping the generator leaves the clock low
  a_r4_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !lvl_q);

endmodule

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  assign expired_o = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= W'(RST_VAL);
    else if (load_i)      cnt_q <= load_val_i;
    else if (!expired_o)  cnt_q <= cnt_q - 1'b1;
  end

  // R8: an expired timer stays expired until reloaded
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && !load_i) |=> expired_o);

endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture
  import adc_rd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdat_i,
  input  logic             clear_i,
  input  logic             take_i,
  output logic             data_rise_o,
  output logic [CAP_W-1:0] cap_o
);
  logic s1_q, s2_q, s3_q;
  logic [CAP_W-1:0] cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= sdat_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign data_rise_o = s2_q && !s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_q <= '0;
    else if (clear_i) cap_q <= '0;
    else if (take_i)  cap_q <= {cap_q[CAP_W-2:0], s2_q};
  end

  assign cap_o = cap_q;

  // R5: a frame never clears and samples in the same cycle
  a_r5_take_not_clear: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> !clear_i);

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int DIV_HALF  = 4,
  parameter int CONV_TMO  = 60,
  parameter int CSHI_CYC  = 6,
  parameter int ABORT_CYC = 20,
  parameter int PWRUP_CYC = 40,
  parameter int WAKE_CYC  = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             byte_mode_i,
  input  logic             wake_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o,
  output logic             timeout_o,
  output logic             cs_n_o,
  output logic             sclk_o,
  input  logic             sdat_i
);
  localparam int TMR_MAX = max_of(max_of(max_of(CONV_TMO, CSHI_CYC), max_of(ABORT_CYC, PWRUP_CYC)),
                                  max_of(WAKE_CYC, DIV_HALF));
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int CHK_W   = TMR_W + 2;

  rd_state_e        state_q;
  logic             cs_n_q, done_q, tmo_q, bm_q;
  logic [RES_W-1:0] res_q;
  logic [BCNT_W-1:0] bit_cnt_q;

  // named internal events
  logic sclk_rise, sclk_fall, data_rise, tmr_exp;
  logic start_acc, wake_acc, eoc_seen, conv_tmo, frame_end, tail_done, hold_done;
  logic run_sclk, cap_take;
  logic tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic [CAP_W-1:0] cap;

  assign start_acc = (state_q == ST_IDLE) && start_i;
  assign wake_acc  = (state_q == ST_IDLE) && !start_i && wake_i;
  assign eoc_seen  = (state_q == ST_CONV) && data_rise;
  assign conv_tmo  = (state_q == ST_CONV) && !data_rise && tmr_exp;
  assign frame_end = (state_q == ST_SHIFT) && sclk_fall && (bit_cnt_q == frame_len(bm_q));
  assign tail_done = (state_q == ST_TAIL) && tmr_exp;
  assign hold_done = (state_q == ST_HOLD) && tmr_exp;
  assign run_sclk  = (state_q == ST_SHIFT);
  assign cap_take  = (state_q == ST_SHIFT) && sclk_rise;

  always_comb begin
    tmr_load = 1'b1;
    tmr_val  = '0;
    if (start_acc)      tmr_val = TMR_W'(CONV_TMO);
    else if (wake_acc)  tmr_val = TMR_W'(WAKE_CYC);
    else if (conv_tmo)  tmr_val = TMR_W'(ABORT_CYC);
    else if (frame_end) tmr_val = TMR_W'(DIV_HALF);
    else if (tail_done) tmr_val = TMR_W'(CSHI_CYC);
    else                tmr_load = 1'b0;
  end

  adc_rd_sclk_gen #(.DIV_HALF(DIV_HALF)) u_sclk (
    .clk(clk), .rst_n(rst_n), .run_i(run_sclk),
    .sclk_o(sclk_o), .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  adc_rd_timer #(.W(TMR_W), .RST_VAL(PWRUP_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
    .expired_o(tmr_exp)
  );

  adc_rd_capture u_cap (
    .clk(clk), .rst_n(rst_n), .sdat_i(sdat_i), .clear_i(start_acc),
    .take_i(cap_take), .data_rise_o(data_rise), .cap_o(cap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_HOLD;
      cs_n_q    <= 1'b1;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
      bm_q      <= 1'b0;
      res_q     <= '0;
      bit_cnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_HOLD: if (hold_done) state_q <= ST_IDLE;
        ST_IDLE: begin
          if (start_acc) begin
            state_q   <= ST_CONV;
            cs_n_q    <= 1'b0;
            bm_q      <= byte_mode_i;
            tmo_q     <= 1'b0;
            bit_cnt_q <= '0;
          end else if (wake_acc) begin
            state_q <= ST_HOLD;
          end
        end
        ST_CONV: begin
          if (eoc_seen) begin
            state_q <= ST_SHIFT;
          end else if (conv_tmo) begin
            state_q <= ST_HOLD;
            cs_n_q  <= 1'b1;
            done_q  <= 1'b1;
            tmo_q   <= 1'b1;
            res_q   <= '0;
          end
        end
        ST_SHIFT: begin
          if (cap_take)  bit_cnt_q <= bit_cnt_q + 1'b1;
          if (frame_end) state_q   <= ST_TAIL;
        end
        ST_TAIL: begin
          if (tail_done) begin
            state_q <= ST_HOLD;
            cs_n_q  <= 1'b1;
            done_q  <= 1'b1;
            res_q   <= extract_result(cap, bm_q);
          end
        end
        default: state_q <= ST_HOLD;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign result_o  = res_q;
  assign timeout_o = tmo_q;
  assign cs_n_o    = cs_n_q;

  // ---------------- checker counters ----------------
  logic [CHK_W-1:0] lvl_cnt, cs_hi_cnt;
  logic             sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_cnt   <= '0;
      cs_hi_cnt <= '0;
      sclk_d    <= 1'b0;
    end else begin
      sclk_d <= sclk_o;
      if (sclk_o != sclk_d)  lvl_cnt <= CHK_W'(1);
      else if (lvl_cnt != '1) lvl_cnt <= lvl_cnt + 1'b1;
      if (!cs_n_o)             cs_hi_cnt <= '0;
      else if (cs_hi_cnt != '1) cs_hi_cnt <= cs_hi_cnt + 1'b1;
    end
  end

  a_r4_clk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  a_r2_quiet_in_conv: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV) |-> !sclk_o);

  a_r4_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> (lvl_cnt == CHK_W'(DIV_HALF)));

  a_r4_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> (lvl_cnt >= CHK_W'(DIV_HALF)));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_done_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $rose(cs_n_o));

  a_r8_cs_high_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (cs_hi_cnt > CHK_W'(CSHI_CYC)));

  a_r9_timeout_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> (done_o && (result_o == '0)));

  a_r1_hold_keeps_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |-> cs_n_o);

endmodule

// File: tb/adc_rd_ctrl_tb_top.sv
module adc_rd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DH   = 5;
  localparam int TMO  = 60;
  localparam int CSHI = 6;
  localparam int ABT  = 20;
  localparam int PWR  = 40;
  localparam int WAK  = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, byte_mode_i = 1'b0, wake_i = 1'b0;
  logic busy_o, done_o, timeout_o, cs_n_o, sclk_o, sdat_i;
  logic [9:0] result_o;

  always #(CLK_PERIOD/2) clk = !clk;

  adc_rd_ctrl #(.DIV_HALF(DH), .CONV_TMO(TMO), .CSHI_CYC(CSHI), .ABORT_CYC(ABT),
                .PWRUP_CYC(PWR), .WAKE_CYC(WAK)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_mode_i(byte_mode_i),
    .wake_i(wake_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
    .timeout_o(timeout_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sdat_i(sdat_i)
  );

  int n_chk = 0, n_err = 0;
  task automatic chk(bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  logic [9:0] m_code = '0;
  logic [1:0] m_sub = '0;
  int         m_conv = 10;
  bit         m_noeoc = 1'b0;
  logic       m_eoc = 1'b0;
  int         m_cnt = 0, m_idx = 0;
  logic       m_psclk = 1'b0;

  function automatic logic model_bit(int idx, logic [9:0] c, logic [1:0] s);
    if (idx == 0) return 1'b1;
    if (idx <= 10) return c[10-idx];
    if (idx == 11) return s[1];
    if (idx == 12) return s[0];
    return 1'b0;
  endfunction

  assign sdat_i = cs_n_o ? 1'b1 : (m_eoc ? model_bit(m_idx, m_code, m_sub) : 1'b0);

  always @(posedge clk) begin
    m_psclk <= sclk_o;
    if (cs_n_o) begin
      m_eoc <= 1'b0; m_cnt <= 0; m_idx <= 0;
    end else begin
      if (!m_eoc) begin
        m_cnt <= m_cnt + 1;
        if (!m_noeoc && (m_cnt + 1 == m_conv)) m_eoc <= 1'b1;
      end
      if (m_psclk && !sclk_o) m_idx <= m_idx + 1;
    end
  end

  // ---------------- reference model and monitor ----------------
  typedef struct { logic [9:0] code; bit bm; bit ab; } exp_t;
  exp_t exp_q[$];

  int  cyc = 0, lvl = 0, rises = 0, hi_cnt = 0, frames = 0;
  int  fall_cyc = 0, rise_cyc = 0, eoc_cyc = 0, hold_kind = 0;
  logic p_cs = 1'b1, p_sclk = 1'b0, p_busy = 1'b1, p_done = 1'b0, p_eoc = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(!(cs_n_o && sclk_o), "R4 sclk high with cs high", int'(sclk_o), 0);
      chk(!(!cs_n_o && sclk_o && !m_eoc), "R2 sclk during conversion", int'(sclk_o), 0);
      if (m_eoc && !p_eoc) eoc_cyc = cyc;
      if (sclk_o != p_sclk) begin
        if (p_sclk) chk(lvl == DH, "R4 high phase length", lvl, DH);
        else if (rises > 0) chk(lvl == DH, "R4 low phase length", lvl, DH);
        if (sclk_o) begin
          rises++;
          if (rises == 1) chk(cyc - eoc_cyc == DH + 3, "R3 eoc to first rise", cyc - eoc_cyc, DH + 3);
        end
        lvl = 1;
      end else lvl++;
      if (p_cs && !cs_n_o) begin
        chk(hi_cnt > CSHI, "R8 cs high time", hi_cnt, CSHI + 1);
        frames++; rises = 0; fall_cyc = cyc;
      end
      if (!p_cs && cs_n_o) begin
        rise_cyc = cyc;
        chk(done_o == 1'b1, "R7 done with cs rise", int'(done_o), 1);
        chk(lvl >= DH && !sclk_o, "R7 sclk low before cs rise", lvl, DH);
        if (exp_q.size() == 0) chk(1'b0, "R12 unexpected frame", frames, 0);
        else if (exp_q[0].ab) begin
          hold_kind = 2;
          chk(cyc - fall_cyc == TMO + 1, "R9 timeout length", cyc - fall_cyc, TMO + 1);
          chk(rises == 0, "R9 no clocks on timeout", rises, 0);
        end else begin
          hold_kind = 1;
          if (exp_q[0].bm) chk(rises == 16, "R6 byte mode clock count", rises, 16);
          else             chk(rises == 11, "R5 short mode clock count", rises, 11);
        end
      end
      if (p_done) chk(!done_o, "R7 done one cycle", int'(done_o), 0);
      if (done_o && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.ab) begin
          chk(result_o == 10'd0, "R9 result on timeout", int'(result_o), 0);
          chk(timeout_o == 1'b1, "R9 timeout flag", int'(timeout_o), 1);
        end else begin
          chk(result_o == e.code, e.bm ? "R6 byte mode result" : "R5 short mode result",
              int'(result_o), int'(e.code));
          chk(timeout_o == 1'b0, "R9 timeout flag cleared", int'(timeout_o), 0);
        end
      end
      if (p_busy && !busy_o) begin
        if (hold_kind == 1) chk(cyc - rise_cyc == CSHI + 1, "R8 hold after frame", cyc - rise_cyc, CSHI + 1);
        if (hold_kind == 2) chk(cyc - rise_cyc == ABT + 1, "R10 hold after timeout", cyc - rise_cyc, ABT + 1);
        hold_kind = 0;
      end
      hi_cnt = cs_n_o ? hi_cnt + 1 : 0;
    end
    p_cs = cs_n_o; p_sclk = sclk_o; p_busy = busy_o; p_done = done_o; p_eoc = m_eoc;
  end

  // ---------------- stimulus ----------------
  task automatic run_conv(logic [9:0] code, logic [1:0] sub, bit bm, int conv, bit ab,
                          bit poke_busy);
    exp_t e;
    while (busy_o) @(negedge clk);
    m_code = code; m_sub = sub; m_conv = conv; m_noeoc = ab;
    e.code = code; e.bm = bm; e.ab = ab;
    exp_q.push_back(e);
    start_i = 1'b1; byte_mode_i = bm;
    @(negedge clk);
    start_i = 1'b0; byte_mode_i = !bm;
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    do @(negedge clk); while (!done_o);
    if (poke_busy) begin
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    int cnt;
    int f0;
    repeat (3) @(negedge clk);
    chk(cs_n_o == 1'b1, "R1 reset cs_n", int'(cs_n_o), 1);
    chk(sclk_o == 1'b0, "R1 reset sclk", int'(sclk_o), 0);
    chk(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
    chk(busy_o == 1'b1, "R1 reset busy", int'(busy_o), 1);
    rst_n = 1'b1;
    cnt = 0;
    repeat (2) begin @(negedge clk); cnt++; end
    start_i = 1'b1;
    repeat (3) begin @(negedge clk); cnt++; end
    start_i = 1'b0;
    while (busy_o) begin @(negedge clk); cnt++; end
    chk(cnt >= PWR, "R1 power-up hold length", cnt, PWR);
    chk(frames == 0, "R1 start ignored during power-up", frames, 0);

    run_conv(10'h2A5, 2'b11, 1'b0, 20, 1'b0, 1'b0);
    run_conv(10'h3FF, 2'b01, 1'b0, 7,  1'b0, 1'b0);
    run_conv(10'h000, 2'b11, 1'b1, 30, 1'b0, 1'b0);
    run_conv(10'h155, 2'b10, 1'b1, 12, 1'b0, 1'b0);
    run_conv(10'h3FF, 2'b00, 1'b1, 50, 1'b0, 1'b0);
    run_conv(10'h123, 2'b11, 1'b0, 1,  1'b1, 1'b0);
    run_conv(10'h201, 2'b01, 1'b0, 15, 1'b0, 1'b0);

    f0 = frames;
    run_conv(10'h0F0, 2'b11, 1'b1, 18, 1'b0, 1'b1);
    while (busy_o) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(frames == f0 + 1, "R12 start while busy", frames - f0, 1);

    f0 = frames;
    wake_i = 1'b1;
    @(negedge clk);
    wake_i = 1'b0;
    cnt = 0;
    while (busy_o) begin cnt++; @(negedge clk); end
    chk(cnt == WAK + 1, "R11 wake hold length", cnt, WAK + 1);
    chk(frames == f0, "R11 no frame on wake", frames - f0, 0);

    run_conv(10'h001, 2'b10, 1'b0, 9, 1'b0, 1'b0);
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all conversions completed", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule